// File: doc/BRIEF.md
# Tamper Timestamp Capture Unit

This block records the moment a tamper event happens on an active-low timestamp input. Two comparator outputs observe that input from outside the block. One goes high once the pin has been pulled down to an intermediate level. The other goes high once the pin has been pulled all the way to ground. When an event is confirmed, the block copies the 48-bit packed calendar word supplied by the clock core into a holding register in a single cycle. It then sets event flags and, when enabled, raises an interrupt request.

A pull that stops at the intermediate level sets the partial-event flag only. A pull that reaches ground sets the partial-event flag and the ground-event flag. Both comparator outputs pass through a two-flop synchronizer. An intermediate reading must persist for a settle window before it is accepted, so a press that continues down to ground is classified as a ground event. After an event, nothing new is recognised until the pin has been released and falls again.

A small register-style bus holds the controls: a disable bit (cleared, so capture is enabled, after reset) and an interrupt-enable bit. Flags are cleared by writing ones. The same bus reads back the flags and the captured word with one cycle of read latency.

Top module: `tamper_stamp`

## Requirements
- R1: After reset the disable bit, interrupt enable, both flags, the captured word, `irq` and `bus_rdata` are all zero, so capture is enabled.
- R2: Register map with 16-bit data: address 0 is control (bit 0 disable, bit 1 interrupt enable, read/write); address 1 is flags (bit 0 partial flag, bit 1 ground flag); addresses 2, 3 and 4 return the captured word bits 15:0, 31:16 and 47:32. `bus_rdata` shows the addressed register one clock after `bus_addr` is presented.
- R3: A level reported by `lvl_mid` that lasts the settle window (4 synchronized cycles) without `lvl_gnd` is an intermediate event. It captures `cal_now` atomically and sets the partial flag only. A shorter pulse produces no event.
- R4: `lvl_gnd` going high, either inside the settle window or while an intermediate press is held, is a ground event. It captures `cal_now`, overwriting any earlier capture, and sets both flags.
- R5: `irq` is high exactly when interrupt enable and the partial flag are both set. It changes in the same cycle as the flag or enable register.
- R6: Writing address 1 clears each flag whose data bit is 1 (bit 0 partial, bit 1 ground) and leaves the other flag unchanged. Clearing the partial flag drops `irq`. An event in the same cycle as a clear wins, and the flag stays set.
- R7: While the input remains held low after an event, a cleared flag is not set again. After release, a fresh fall re-arms detection.
- R8: While the disable bit is set, presses are ignored and flags and the captured word hold. A press that is still held when the block is re-enabled produces no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_mid | input | 1 | Comparator: pin at or below the intermediate level (asynchronous) |
| lvl_gnd | input | 1 | Comparator: pin at ground (asynchronous) |
| cal_now | input | 48 | Packed current date and time from the clock core |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The host clear of the partial flag and a newly confirmed event can land in the same cycle. The clear must then lose. The bench provokes this by counting the two synchronizer stages and the four settle cycles from the moment `lvl_mid` rises, then placing the clear write in the exact cycle the event is registered. Afterwards it reads the flags back and expects the partial flag still set; if the clear won, the flag would read zero.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  typedef enum logic [1:0] {
    CL_IDLE,
    CL_SETTLE,
    CL_MIDHELD,
    CL_WAITREL
  } cls_state_e;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
    logic [7:0] hours;
    logic [7:0] minutes;
    logic [7:0] seconds;
  } cal_word_t;

  localparam int unsigned CSR_CTRL   = 0;
  localparam int unsigned CSR_FLAGS  = 1;
  localparam int unsigned CSR_STAMP0 = 2;
endpackage

// File: rtl/tstamp_sync.sv
module tstamp_sync #(
  parameter int W = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0] chain [W];

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) chain[b] <= '0;
      else     chain[b] <= {chain[b][STAGES-2:0], d[b]};
    end
    assign q[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/tstamp_classify.sv
module tstamp_classify
  import tstamp_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic dis,
  input  logic mid_s,
  input  logic gnd_s,
  output logic ev_mid,
  output logic ev_gnd
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  cls_state_e    st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          lvl;

  assign lvl = mid_s | gnd_s;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    ev_mid = 1'b0;
    ev_gnd = 1'b0;
    if (dis) begin
      st_n  = lvl ? CL_WAITREL : CL_IDLE;
      cnt_n = '0;
    end else begin
      case (st)
        CL_IDLE: begin
          cnt_n = '0;
          if (gnd_s) begin
            ev_gnd = 1'b1;
            st_n   = CL_WAITREL;
          end else if (lvl) begin
            st_n = CL_SETTLE;
          end
        end
        CL_SETTLE: begin
          if (gnd_s) begin
            ev_gnd = 1'b1;
            st_n   = CL_WAITREL;
          end else if (!mid_s) begin
            st_n = CL_IDLE;
          end else if (cnt == LAST) begin
            ev_mid = 1'b1;
            st_n   = CL_MIDHELD;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        CL_MIDHELD: begin
          if (gnd_s) begin
            ev_gnd = 1'b1;
            st_n   = CL_WAITREL;
          end else if (!lvl) begin
            st_n = CL_IDLE;
          end
        end
        default: begin
          if (!lvl) st_n = CL_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= CL_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/tstamp_regs.sv
module tstamp_regs
  import tstamp_pkg::*;
#(
  parameter int STAMP_W = 48,
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic               ev_mid,
  input  logic               ev_gnd,
  input  logic [STAMP_W-1:0] cal_now,
  output logic [DW-1:0]      rdata,
  output logic               irq,
  output logic               dis,
  output logic               ien,
  output logic               f1,
  output logic               f2,
  output logic [STAMP_W-1:0] stamp
);
  localparam int NWORDS = STAMP_W / DW;

  logic          ev_any, wr_ctrl, wr_flags;
  logic          dis_n, ien_n, f1_n, f2_n;
  logic [DW-1:0] rd_n;

  assign ev_any   = ev_mid | ev_gnd;
  assign wr_ctrl  = we && (addr == AW'(CSR_CTRL));
  assign wr_flags = we && (addr == AW'(CSR_FLAGS));

  always_comb begin
    dis_n = wr_ctrl ? wdata[0] : dis;
    ien_n = wr_ctrl ? wdata[1] : ien;
    f1_n  = f1;
    f2_n  = f2;
    if (wr_flags && wdata[0]) f1_n = 1'b0;
    if (wr_flags && wdata[1]) f2_n = 1'b0;
    if (ev_any) f1_n = 1'b1;
    if (ev_gnd) f2_n = 1'b1;
  end

  always_comb begin
    rd_n = '0;
    if (addr == AW'(CSR_CTRL))  rd_n[1:0] = {ien, dis};
    if (addr == AW'(CSR_FLAGS)) rd_n[1:0] = {f2, f1};
    for (int k = 0; k < NWORDS; k++) begin
      if (addr == AW'(CSR_STAMP0 + k)) rd_n = stamp[k*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dis   <= 1'b0;
      ien   <= 1'b0;
      f1    <= 1'b0;
      f2    <= 1'b0;
      irq   <= 1'b0;
      stamp <= '0;
      rdata <= '0;
    end else begin
      dis   <= dis_n;
      ien   <= ien_n;
      f1    <= f1_n;
      f2    <= f2_n;
      irq   <= ien_n & f1_n;
      rdata <= rd_n;
      if (ev_any) stamp <= cal_now;
    end
  end
endmodule

// File: rtl/tamper_stamp.sv
module tamper_stamp
  import tstamp_pkg::*;
#(
  parameter int STAMP_W = 48,
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int SETTLE = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lvl_mid,
  input  logic               lvl_gnd,
  input  logic [STAMP_W-1:0] cal_now,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq
);
  logic [1:0]         lvl_s;
  logic               ev_mid, ev_gnd;
  logic               ctl_dis, ctl_ien, flag1, flag2;
  logic [STAMP_W-1:0] stamp_q;

  tstamp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({lvl_gnd, lvl_mid}), .q(lvl_s)
  );

  tstamp_classify #(.SETTLE(SETTLE)) u_cls (
    .clk(clk), .rst(rst), .dis(ctl_dis),
    .mid_s(lvl_s[0]), .gnd_s(lvl_s[1]),
    .ev_mid(ev_mid), .ev_gnd(ev_gnd)
  );

  tstamp_regs #(.STAMP_W(STAMP_W), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .ev_mid(ev_mid), .ev_gnd(ev_gnd), .cal_now(cal_now),
    .rdata(bus_rdata), .irq(irq), .dis(ctl_dis), .ien(ctl_ien),
    .f1(flag1), .f2(flag2), .stamp(stamp_q)
  );
endmodule

// File: rtl/tamper_stamp_chk.sv
module tamper_stamp_chk #(
  parameter int STAMP_W = 48,
  parameter int DW = 16,
  parameter int AW = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_we,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic               irq,
  input logic               ev_mid,
  input logic               ev_gnd,
  input logic               ctl_dis,
  input logic               ctl_ien,
  input logic               flag1,
  input logic               flag2,
  input logic [STAMP_W-1:0] stamp_q
);
  logic clr1, wr_ctrl;
  assign clr1    = bus_we && (bus_addr == AW'(1)) && bus_wdata[0];
  assign wr_ctrl = bus_we && (bus_addr == AW'(0));

  AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (clr1 && !ev_mid && !ev_gnd) |=> !irq); // R6
  AST_EVT_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    ((ev_mid || ev_gnd) && ctl_ien && !wr_ctrl) |=> irq); // R5
  AST_GND_SETS_BOTH: assert property (@(posedge clk) disable iff (rst)
    ev_gnd |=> (flag1 && flag2)); // R4
  AST_DIS_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    ctl_dis |-> !(ev_mid || ev_gnd)); // R8
  AST_DIS_HOLDS_STAMP: assert property (@(posedge clk) disable iff (rst)
    ctl_dis |=> $stable(stamp_q)); // R8
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_mid, ev_gnd})); // R3
endmodule

bind tamper_stamp tamper_stamp_chk #(.STAMP_W(STAMP_W), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .ev_mid(ev_mid), .ev_gnd(ev_gnd),
  .ctl_dis(ctl_dis), .ctl_ien(ctl_ien), .flag1(flag1), .flag2(flag2),
  .stamp_q(stamp_q)
);

// File: tb/tamper_stamp_bench.sv
`timescale 1ns/1ps
module tamper_stamp_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lvl_mid = 1'b0;
  logic        lvl_gnd = 1'b0;
  logic [47:0] cal_now = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tamper_stamp u_tamper_stamp (
    .clk(clk), .rst(rst), .lvl_mid(lvl_mid), .lvl_gnd(lvl_gnd),
    .cal_now(cal_now), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic read_stamp(output logic [47:0] s);
    logic [15:0] w;
    for (int k = 0; k < 3; k++) begin
      bus_read(3'(2 + k), w);
      s[k*16 +: 16] = w;
    end
  endtask

  initial begin
    logic [15:0] r;
    logic [47:0] s;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 rdata", bus_rdata, 0);
    bus_read(0, r); check("R1 ctrl", r, 0);
    bus_read(1, r); check("R1 flags", r, 0);
    read_stamp(s);  check("R1 stamp", s, 0);

    // R2 control readback
    bus_write(0, 16'h0002);
    bus_read(0, r); check("R2 ctrl readback", r, 16'h0002);

    // R3 short pulse ignored
    cal_now = 48'h1111_2222_3333;
    lvl_mid = 1; idle(2); lvl_mid = 0; idle(10);
    bus_read(1, r); check("R3 short pulse flags", r, 0);
    check("R5 no irq after glitch", irq, 0);

    // R3 intermediate event
    cal_now = 48'h2401_1512_3045;
    lvl_mid = 1; idle(12);
    cal_now = 48'h2401_1512_3046;
    bus_read(1, r); check("R3 mid flags", r, 16'h0001);
    check("R5 irq on partial", irq, 1);
    read_stamp(s); check("R3 mid stamp", s, 48'h2401_1512_3045);

    // R4 escalation to ground overwrites
    lvl_gnd = 1; idle(10);
    cal_now = 48'h2401_1512_3050;
    bus_read(1, r); check("R4 gnd flags", r, 16'h0003);
    read_stamp(s); check("R4 gnd stamp", s, 48'h2401_1512_3046);

    // R6 clear flag1 only, R7 held low
    bus_write(1, 16'h0001);
    bus_read(1, r); check("R6 clear bit0 keeps bit1", r, 16'h0002);
    check("R6 irq dropped", irq, 0);
    idle(20);
    bus_read(1, r); check("R7 held low no reset", r, 16'h0002);
    check("R7 irq stays low", irq, 0);
    bus_write(1, 16'h0002);
    bus_read(1, r); check("R6 clear bit1", r, 0);

    // R7 release and fresh direct ground press
    lvl_mid = 0; lvl_gnd = 0; idle(8);
    cal_now = 48'h2402_0101_0000;
    lvl_mid = 1; lvl_gnd = 1; idle(10);
    cal_now = 48'h2402_0101_0001;
    bus_read(1, r); check("R7 rearm direct gnd flags", r, 16'h0003);
    read_stamp(s); check("R4 direct gnd stamp", s, 48'h2402_0101_0000);
    lvl_mid = 0; lvl_gnd = 0; idle(8);

    // R5 irq follows enable
    bus_write(0, 16'h0000); idle(1);
    check("R5 irq off with enable clear", irq, 0);
    bus_write(0, 16'h0002); idle(1);
    check("R5 irq on with enable set", irq, 1);
    bus_write(1, 16'h0003);
    bus_read(1, r); check("R6 clear both", r, 0);

    // R6 clear collides with event: set flag1 first
    cal_now = 48'h2403_0202_0000;
    lvl_mid = 1; idle(12); lvl_mid = 0; idle(8);
    cal_now = 48'h2403_0202_0101;
    lvl_mid = 1;
    idle(6);
    bus_write(1, 16'h0001);
    idle(4);
    bus_read(1, r); check("R6 event wins over clear", r, 16'h0001);
    check("R5 irq after collision", irq, 1);
    read_stamp(s); check("R3 collision stamp", s, 48'h2403_0202_0101);
    lvl_mid = 0; idle(8);
    bus_write(1, 16'h0003);

    // R8 disabled press ignored
    bus_write(0, 16'h0003);
    cal_now = 48'h2404_0303_0000;
    lvl_mid = 1; lvl_gnd = 1; idle(12);
    bus_read(1, r); check("R8 disabled flags", r, 0);
    check("R8 disabled irq", irq, 0);
    read_stamp(s); check("R8 disabled stamp", s, 48'h2403_0202_0101);
    bus_write(0, 16'h0002); idle(12);
    bus_read(1, r); check("R8 reenable while held", r, 0);
    read_stamp(s); check("R8 reenable stamp held", s, 48'h2403_0202_0101);
    lvl_mid = 0; lvl_gnd = 0; idle(8);
    cal_now = 48'h2404_0303_0707;
    lvl_mid = 1; idle(12);
    bus_read(1, r); check("R8 after reenable fresh press", r, 16'h0001);
    read_stamp(s); check("R8 fresh stamp", s, 48'h2404_0303_0707);
    lvl_mid = 0; idle(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule